// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns 32-bit addresses issued by DMA-capable devices into 41-bit physical addresses. It does this by looking up one 64-bit descriptor in a translation table that sits in system memory. Software sets up the unit through two 64-bit registers, a control word and a table base. Each register can be reached as a whole or as two 32-bit halves. A dummy flush location completes the register window.

A requester offers an address with a valid/ready handshake, and the unit accepts one address at a time. If translation is off, the address comes straight back with read/write access. If translation is on, the unit works out the descriptor address from the table page size and the table size code. It then issues a single memory read over a request/ready plus response-valid handshake and decodes the descriptor it receives. The result is presented for exactly one cycle on `done_o`: a physical address, a write permission and a fault flag. A fault means no access.

Top module: `dma_xlate`

## Requirements
- R1: After reset both registers read as zero, `xl_ready_o` is high, and `done_o` and `mem_req_o` are low.
- R2: The register window works as follows:
  - Offset 0x0 holds control and offset 0x8 holds base.
  - A 32-bit access at the register's own offset reaches bits 63:32, using data bits 31:0.
  - A 32-bit access at offset +4 reaches bits 31:0.
  - A 64-bit access (`reg_wide_i` = 1) reaches the whole register.
  - In a 32-bit read, bits 63:32 of `reg_rdata_o` are zero.
- R3: Offsets 0x10 and 0x14 read as zero. Writes there leave both registers unchanged.
- R4: When control bit 0 is clear, an accepted address completes on the cycle after acceptance. The result is `pa_o` equal to the address, `wr_ok_o` = 1 and `fault_o` = 0, and no memory read is issued.
- R5: When control bit 0 is set and control bit 2 is clear (8K table), the descriptor address is base + 8 × ((addr >> 13) mod 2^(10+s)), where s is control bits 18:16. `mem_addr_o` holds steady while `mem_req_o` waits for `mem_ready_i`.
- R6: When control bit 2 is set (64K table) and s ≤ 5, the descriptor address is base + 8 × ((addr >> 16) mod 2^(10+s)).
- R7: With a 64K table and s of 6 or 7, the unit reports a fault on the cycle after acceptance and issues no memory read.
- R8: A descriptor whose bit 63 is clear gives `fault_o` = 1, `wr_ok_o` = 0 and `pa_o` = 0.
- R9: For a valid descriptor, `wr_ok_o` equals descriptor bit 1.
- R10: For a valid descriptor, bit 61 chooses the mapping size, and this choice is independent of the table page size.
  - When bit 61 is set, `pa_o` = {descriptor[40:16], addr[15:0]}.
  - When bit 61 is clear, `pa_o` = {descriptor[40:13], addr[12:0]}.
- R11: `done_o` is a single-cycle pulse, and the next cycle `xl_ready_o` is high again. `xl_ready_o` stays low from acceptance until `done_o`. `done_o` comes on the cycle after the `mem_rvalid_i` beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wide_i | input | 1 | 64-bit access when high, 32-bit when low |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i |
| xl_valid_i | input | 1 | Translation request valid |
| xl_ready_o | output | 1 | Unit idle and accepting |
| xl_addr_i | input | 32 | Device address to translate |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 1 | No access granted |
| wr_ok_o | output | 1 | Write permitted |
| pa_o | output | 41 | Physical address |
| mem_req_o | output | 1 | Descriptor read request |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 64 | Descriptor byte address |
| mem_rvalid_i | input | 1 | Descriptor data valid |
| mem_rdata_i | input | 64 | Descriptor as a 64-bit value |

## Verification
The assertions rely on a few properties of the memory side:
- `mem_rvalid_i` arrives only after a request has been granted by `mem_ready_i`.
- Each granted request gets exactly one response beat.
- `mem_ready_i` is never raised when no request is pending.

The bench's memory model keeps to these rules. It raises the grant once per request, after a chosen stall, and then returns a single data beat after a separate delay. Register writes take place only while the unit is idle, so the configuration captured at acceptance always matches the bench's model.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  localparam int unsigned REG_W         = 64;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_BIG_BIT  = 2;
  localparam int unsigned CTRL_SZ_LSB   = 16;
  localparam int unsigned ENT_VALID_BIT = 63;
  localparam int unsigned ENT_BIG_BIT   = 61;
  localparam int unsigned ENT_WR_BIT    = 1;
  localparam int unsigned SMALL_SHIFT   = 13;
  localparam int unsigned BIG_SHIFT     = 16;
  localparam int unsigned IDX_BASE_W    = 10;
  localparam int unsigned ENTRY_SHIFT   = 3;
  localparam int unsigned MAX_BIG_SZ    = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} xl_state_e;
endpackage

// File: rtl/dxu_regs.sv
module dxu_regs
  import dxu_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             wide_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned HW  = REG_W / 2;
  localparam int unsigned SW  = AW - 3;
  localparam int unsigned NREG = 2;

  logic [SW-1:0] sel;
  assign sel = addr_i[AW-1:3];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] q;
    logic hit;
    assign hit = we_i && (sel == SW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (hit) begin
        if (wide_i)         q <= wdata_i;
        else if (addr_i[2]) q[HW-1:0] <= wdata_i[HW-1:0];
        else                q[REG_W-1:HW] <= wdata_i[HW-1:0];
      end
    end
  end

  assign ctrl_o = g_reg[0].q;
  assign base_o = g_reg[1].q;

  logic [REG_W-1:0] word;
  always_comb begin
    unique case (sel)
      SW'(0):  word = g_reg[0].q;
      SW'(1):  word = g_reg[1].q;
      default: word = '0; // flush and unmapped read as zero
    endcase
    if (wide_i)         rdata_o = word;
    else if (addr_i[2]) rdata_o = {{HW{1'b0}}, word[HW-1:0]};
    else                rdata_o = {{HW{1'b0}}, word[REG_W-1:HW]};
  end
endmodule

// File: rtl/dxu_index.sv
module dxu_index
  import dxu_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic             big_i,
  input  logic [2:0]       sz_i,
  input  logic [REG_W-1:0] base_i,
  output logic [REG_W-1:0] fetch_o,
  output logic             bad_o
);
  logic [VA_W-1:0] pg, mask;
  always_comb begin
    pg      = big_i ? (va_i >> BIG_SHIFT) : (va_i >> SMALL_SHIFT);
    mask    = (VA_W'(1) << (IDX_BASE_W + 32'(sz_i))) - VA_W'(1);
    fetch_o = base_i + (REG_W'(pg & mask) << ENTRY_SHIFT);
    bad_o   = big_i && (32'(sz_i) > MAX_BIG_SZ);
  end
endmodule

// File: rtl/dxu_decode.sv
module dxu_decode
  import dxu_pkg::*;
#(
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 41
) (
  input  logic [REG_W-1:0] entry_i,
  input  logic [VA_W-1:0]  va_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             wr_o,
  output logic             fault_o
);
  always_comb begin
    fault_o = !entry_i[ENT_VALID_BIT];
    wr_o    = !fault_o && entry_i[ENT_WR_BIT];
    if (fault_o)                   pa_o = '0;
    else if (entry_i[ENT_BIG_BIT]) pa_o = {entry_i[PA_W-1:BIG_SHIFT], va_i[BIG_SHIFT-1:0]};
    else                           pa_o = {entry_i[PA_W-1:SMALL_SHIFT], va_i[SMALL_SHIFT-1:0]};
  end
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dxu_pkg::*;
#(
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 41,
  parameter int unsigned AW   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_wide_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             xl_valid_i,
  output logic             xl_ready_o,
  input  logic [VA_W-1:0]  xl_addr_i,
  output logic             done_o,
  output logic             fault_o,
  output logic             wr_ok_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             mem_req_o,
  input  logic             mem_ready_i,
  output logic [REG_W-1:0] mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [REG_W-1:0] mem_rdata_i
);
  logic [REG_W-1:0] ctrl_w, base_w, fetch_w;
  logic             bad_w, dec_wr, dec_fault;
  logic [PA_W-1:0]  dec_pa;

  dxu_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .wide_i(reg_wide_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl_w), .base_o(base_w), .rdata_o(reg_rdata_o)
  );

  dxu_index #(.VA_W(VA_W)) u_index (
    .va_i(xl_addr_i), .big_i(ctrl_w[CTRL_BIG_BIT]), .sz_i(ctrl_w[CTRL_SZ_LSB+:3]),
    .base_i(base_w), .fetch_o(fetch_w), .bad_o(bad_w)
  );

  xl_state_e        state_q;
  logic [VA_W-1:0]  va_q;
  logic [REG_W-1:0] fetch_q;
  logic [PA_W-1:0]  pa_q;
  logic             wr_q, fault_q;

  dxu_decode #(.VA_W(VA_W), .PA_W(PA_W)) u_decode (
    .entry_i(mem_rdata_i), .va_i(va_q),
    .pa_o(dec_pa), .wr_o(dec_wr), .fault_o(dec_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      fetch_q <= '0;
      pa_q    <= '0;
      wr_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (xl_valid_i) begin
          va_q    <= xl_addr_i;
          fetch_q <= fetch_w;
          if (!ctrl_w[CTRL_EN_BIT]) begin
            pa_q    <= PA_W'(xl_addr_i);
            wr_q    <= 1'b1;
            fault_q <= 1'b0;
            state_q <= ST_RESP;
          end else if (bad_w) begin
            pa_q    <= '0;
            wr_q    <= 1'b0;
            fault_q <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          pa_q    <= dec_pa;
          wr_q    <= dec_wr;
          fault_q <= dec_fault;
          state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xl_ready_o = (state_q == ST_IDLE);
  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = fetch_q;
  assign done_o     = (state_q == ST_RESP);
  assign pa_o       = pa_q;
  assign wr_ok_o    = wr_q;
  assign fault_o    = fault_q;
endmodule

// File: rtl/dxu_checker.sv
module dxu_checker #(
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 41
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [63:0]     ctrl_i,
  input logic            xl_valid_i,
  input logic            xl_ready_o,
  input logic [VA_W-1:0] xl_addr_i,
  input logic            done_o,
  input logic            fault_o,
  input logic            wr_ok_o,
  input logic [PA_W-1:0] pa_o,
  input logic            mem_req_o,
  input logic            mem_ready_i,
  input logic [63:0]     mem_addr_o
);
  p_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_i && xl_ready_o && !ctrl_i[0]
    |=> done_o && !fault_o && wr_ok_o && pa_o == PA_W'($past(xl_addr_i)));

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  p_badsz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_i && xl_ready_o && ctrl_i[0] && ctrl_i[2] && ctrl_i[18:16] > 3'd5
    |=> done_o && fault_o && !mem_req_o);

  p_fault_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> !wr_ok_o && pa_o == '0);

  p_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || mem_req_o) |-> !xl_ready_o);

  p_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && xl_ready_o);
endmodule

bind dma_xlate dxu_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk_i, .rst_ni, .ctrl_i(ctrl_w), .xl_valid_i, .xl_ready_o, .xl_addr_i,
  .done_o, .fault_o, .wr_ok_o, .pa_o, .mem_req_o, .mem_ready_i, .mem_addr_o
);

// File: tb/dma_xlate_bench.sv
module dma_xlate_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_wide = 0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic xl_valid = 0, xl_ready;
  logic [31:0] xl_addr = '0;
  logic done, fault, wr_ok;
  logic [40:0] pa;
  logic mem_req, mem_ready = 0, mem_rvalid = 0;
  logic [63:0] mem_addr, mem_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  dma_xlate u_dma_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_wide_i(reg_wide), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xl_valid_i(xl_valid), .xl_ready_o(xl_ready), .xl_addr_i(xl_addr),
    .done_o(done), .fault_o(fault), .wr_ok_o(wr_ok), .pa_o(pa),
    .mem_req_o(mem_req), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  longint unsigned m_ctrl = 0, m_base = 0;
  bit exp_done = 0, exp_rdy = 1, exp_req = 0, mon_on = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  // per-clock comparison of handshake outputs against the model
  always @(negedge clk) if (mon_on) begin
    chk(done == exp_done, "R11 done", 64'(done), 64'(exp_done));
    chk(xl_ready == exp_rdy, "R11 ready", 64'(xl_ready), 64'(exp_rdy));
    chk(mem_req == exp_req, "R4/R7 mem_req", 64'(mem_req), 64'(exp_req));
  end

  task automatic wr_reg(input logic [4:0] a, input bit wide, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
    case (a)
      5'h00: if (wide) m_ctrl = d; else m_ctrl[63:32] = d[31:0];
      5'h04: m_ctrl[31:0] = d[31:0];
      5'h08: if (wide) m_base = d; else m_base[63:32] = d[31:0];
      5'h0C: m_base[31:0] = d[31:0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [4:0] a, input bit wide, input logic [63:0] exp, input string rq);
    @(negedge clk);
    reg_addr = a; reg_wide = wide;
    #1 chk(reg_rdata == exp, rq, reg_rdata, exp);
  endtask

  task automatic xlate(input logic [31:0] a, input logic [63:0] ent, input int lat, input string rq);
    bit en, big;
    int sz;
    longint unsigned off, e41, exp_pa;
    en  = m_ctrl[0];
    big = m_ctrl[2];
    sz  = int'(m_ctrl[18:16]);
    @(negedge clk);
    xl_valid = 1; xl_addr = a;
    @(posedge clk); #1;
    xl_valid = 0; exp_rdy = 0;
    if (!en || (big && sz > 5)) begin
      exp_done = 1;
      @(negedge clk);
      if (!en) begin
        chk(pa == 41'(a), {"R4 pa ", rq}, 64'(pa), 64'(a));
        chk(wr_ok && !fault, {"R4 perm ", rq}, {wr_ok, fault}, 2'b10);
      end else begin
        chk(fault && !wr_ok && pa == 0, {"R7 fault ", rq}, {pa, wr_ok, fault}, 64'b1);
      end
    end else begin
      if (big) off = ((longint'(a) >> 16) % (64'd1 << (10 + sz))) * 8;
      else     off = ((longint'(a) >> 13) % (64'd1 << (10 + sz))) * 8;
      exp_req = 1;
      @(negedge clk);
      chk(mem_addr == m_base + off, {big ? "R6 fetch " : "R5 fetch ", rq}, mem_addr, m_base + off);
      repeat (lat) @(negedge clk);
      mem_ready = 1;
      @(posedge clk); #1;
      mem_ready = 0; exp_req = 0;
      repeat (lat + 1) @(negedge clk);
      mem_rvalid = 1; mem_rdata = ent;
      @(posedge clk); #1;
      mem_rvalid = 0; mem_rdata = '0; exp_done = 1;
      @(negedge clk);
      if (!ent[63]) begin
        chk(fault && !wr_ok && pa == 0, {"R8 invalid ", rq}, {pa, wr_ok, fault}, 64'b1);
      end else begin
        e41 = ent & ((64'd1 << 41) - 1);
        if (ent[61]) exp_pa = ((e41 >> 16) << 16) | (longint'(a) & 64'hFFFF);
        else         exp_pa = ((e41 >> 13) << 13) | (longint'(a) & 64'h1FFF);
        chk(!fault, {"R8 nofault ", rq}, 64'(fault), 64'd0);
        chk(wr_ok == ent[1], {"R9 wr ", rq}, 64'(wr_ok), 64'(ent[1]));
        chk(64'(pa) == exp_pa, {"R10 pa ", rq}, 64'(pa), exp_pa);
      end
    end
    @(posedge clk); #1;
    exp_done = 0; exp_rdy = 1;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL R11 watchdog act=%0d exp=0", 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(xl_ready && !done && !mem_req, "R1 outputs", {xl_ready, done, mem_req}, 3'b100);
    rd_chk(5'h00, 1, 64'd0, "R1 ctrl");
    rd_chk(5'h08, 1, 64'd0, "R1 base");
    mon_on = 1;

    // R2 half access
    wr_reg(5'h00, 0, 64'h0000_0000_A5A5_0000);
    wr_reg(5'h04, 0, 64'hFFFF_FFFF_1234_5678);
    rd_chk(5'h00, 1, 64'hA5A5_0000_1234_5678, "R2 ctrl wide");
    rd_chk(5'h00, 0, 64'h0000_0000_A5A5_0000, "R2 ctrl hi");
    rd_chk(5'h04, 0, 64'h0000_0000_1234_5678, "R2 ctrl lo");
    wr_reg(5'h08, 1, 64'h0000_0001_0000_0000);
    wr_reg(5'h0C, 0, 64'h0000_0000_0000_4000);
    rd_chk(5'h08, 1, 64'h0000_0001_0000_4000, "R2 base wide");
    rd_chk(5'h08, 0, 64'h0000_0000_0000_0001, "R2 base hi");

    // R3 flush
    wr_reg(5'h10, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_reg(5'h14, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk(5'h10, 1, 64'd0, "R3 flush wide");
    rd_chk(5'h14, 0, 64'd0, "R3 flush lo");
    rd_chk(5'h00, 1, m_ctrl, "R3 ctrl kept");
    rd_chk(5'h08, 1, m_base, "R3 base kept");

    // R4 passthrough (bit0 of 0x1234_5678 is clear)
    xlate(32'hDEAD_BEEF, 64'd0, 0, "a");
    wr_reg(5'h00, 1, 64'd0);
    xlate(32'h0000_0000, 64'd0, 0, "b");
    xlate(32'hFFFF_FFFF, 64'd0, 0, "c");

    // R5 8K tables
    wr_reg(5'h00, 1, 64'h0000_0000_0000_0001);
    xlate(32'h00AB_E123, 64'h8000_0123_4567_E002, 0, "8K s0 wr");
    wr_reg(5'h00, 1, 64'h0000_0000_0007_0001);
    xlate(32'hFFFF_FFFF, 64'h8000_01FF_FFFF_E000, 2, "8K s7 ro");
    wr_reg(5'h00, 1, 64'h0000_0000_0003_0001);
    xlate(32'h0765_4321, 64'hA000_00AB_CDEF_8002, 1, "8K s3 big map");

    // R6 64K tables
    wr_reg(5'h00, 1, 64'h0000_0000_0000_0005);
    xlate(32'h0FED_CBA9, 64'hA000_0155_5555_8002, 0, "64K s0");
    wr_reg(5'h00, 1, 64'h0000_0000_0005_0005);
    xlate(32'hFFFF_1234, 64'h8000_0100_0000_E000, 3, "64K s5 small map");

    // R7 unsupported 64K codes
    wr_reg(5'h00, 1, 64'h0000_0000_0006_0005);
    xlate(32'h1234_5678, 64'd0, 0, "s6");
    wr_reg(5'h00, 1, 64'h0000_0000_0007_0005);
    xlate(32'h8765_4321, 64'd0, 0, "s7");

    // R8 invalid entry
    wr_reg(5'h00, 1, 64'h0000_0000_0002_0001);
    xlate(32'h0012_3456, 64'h2000_01FF_FFFF_FFFF, 1, "no valid");

    repeat (3) @(negedge clk);
    mon_on = 0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule